// File: doc/BRIEF.md
# SPI Flash Slave Serial Front-End

This block is the serial edge of a flash-memory slave. The bus-side pins are chip select, serial clock, serial data in, serial data out and an output enable for the data-out pad. The block samples these pins with the device's own system clock and finds the clock edges of the serial bus. It frames the incoming bits into bytes and hands them to a control core. The first byte of every transaction is the command code. The next bytes form the start address, high byte first. Every byte after that is a payload byte.

The core drives response bytes back. It holds a read-enable level and presents the next byte. The front-end takes that byte at each byte boundary, on the falling edge of the serial clock, and acknowledges it with a one-cycle pulse. The serial clock may idle low or high between transactions (SPI modes 0 and 3). No setting selects between them.

Deselecting the device in the middle of a byte drops the partial byte, and the next selection starts again with a command code. The data-out pad is released whenever the device is deselected or in reset.

Top module: `spiflash_serial_frontend`

## Requirements
- R1: While `rst` is high and on the first cycles after it, all strobes (`cmd_valid`, `addr_valid`, `wdat_valid`, `rdat_take`, `frame_done`) are low and `spi_so_oe` is 0.
- R2: `spi_si` is sampled on rising `spi_sck` while `spi_cs_n` is low. The first 8 bits after selection, most significant bit first, appear on `cmd_opcode` with a `cmd_valid` pulse.
- R3: The next ADDR_BYTES (default 3) bytes are joined into `addr_value`, the first received byte in bits 23:16 and the last in bits 7:0, with one `addr_valid` pulse after the last of them.
- R4: Every complete byte after the address appears on `wdat_byte` with its own `wdat_valid` pulse, in arrival order.
- R5: At a falling `spi_sck` that follows a whole number of received bytes while `rdat_en` is high, `rdat_byte` is taken, its bit 7 is driven on `spi_so` at once, `spi_so_oe` is set and `rdat_take` pulses. Each following falling edge drives the next lower bit. `spi_so` changes only after a falling edge.
- R6: An identical transaction in mode 0 (clock idles low) and in mode 3 (clock idles high) yields the same command, address, payload bytes and output bits.
- R7: `spi_so_oe` is 0 whenever `spi_cs_n` is high or `rst` is high, with no clock delay.
- R8: If `spi_cs_n` rises partway through a byte, that byte produces no strobe. `frame_whole` reads 0 with the `frame_done` pulse, and the next transaction starts a fresh command byte.
- R9: Each rise of `spi_cs_n` gives one `frame_done` pulse. `frame_whole` is 1 if the transaction ended on a byte boundary.
- R10: `cmd_valid`, `addr_valid` and `wdat_valid` are single-cycle pulses, never two at once, and a transaction gives at most one `cmd_valid` and one `addr_valid`.
- R11: At a byte-boundary falling edge with `rdat_en` low, `spi_so_oe` goes to or stays 0. During the command and address bytes of a transaction the pad is therefore never driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the bus master |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data from the master |
| spi_so | output | 1 | Serial data to the master, valid when enabled |
| spi_so_oe | output | 1 | Output enable for the data-out pad |
| cmd_valid | output | 1 | Pulse: command byte received |
| cmd_opcode | output | 8 | Last received command byte |
| addr_valid | output | 1 | Pulse: address complete |
| addr_value | output | 24 | Assembled address |
| wdat_valid | output | 1 | Pulse: payload byte received |
| wdat_byte | output | 8 | Last payload byte |
| rdat_en | input | 1 | Core wants response bytes driven |
| rdat_byte | input | 8 | Next response byte |
| rdat_take | output | 1 | Pulse: response byte taken |
| frame_done | output | 1 | Pulse: chip select released |
| frame_whole | output | 1 | Transaction ended on a byte boundary |

## Verification
A bit counter that is off by one shows up as a wrong command or address value at the first strobe, about three system clocks after the eighth or thirty-second rising edge. A counter that is not cleared on deselect shows up as a shifted command byte in the following transaction. A wrong boundary test on the output side puts a shifted byte or a driven pad on the wire before the next rising serial clock edge, so the master sees it within one bit time. Running each transaction once with the clock idling low and once idling high catches logic that relies on edge order at selection.

// File: rtl/spiflash_fe_pkg.sv
package spiflash_fe_pkg;
    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [BIT_W-1:0]  bitidx_t;

    typedef enum logic [1:0] {
        PH_OPCODE  = 2'd0,
        PH_ADDRESS = 2'd1,
        PH_PAYLOAD = 2'd2
    } frame_phase_e;

    // Events seen by the receive framer, one clk cycle each
    typedef struct packed {
        logic cs_act;
        logic cs_stop;
        logic sck_rise;
        logic si_bit;
    } rx_events_t;

    function automatic byte_t push_msb_first(byte_t cur, logic b);
        return {cur[BYTE_W-2:0], b};
    endfunction

    function automatic logic last_bit(bitidx_t c);
        return c == bitidx_t'(BYTE_W - 1);
    endfunction

    function automatic logic at_byte_edge(bitidx_t c);
        return c == '0;
    endfunction
endpackage

// File: rtl/spiflash_pin_sync.sv
module spiflash_pin_sync
    import spiflash_fe_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck_pin,
    input  logic       cs_n_pin,
    input  logic       si_pin,
    output rx_events_t rx_ev,
    output logic       sck_fall
);
    logic [STAGES-1:0] sck_ch;
    logic [STAGES-1:0] cs_ch;
    logic [STAGES-1:0] si_ch;
    logic              sck_prev;
    logic              cs_prev;
    logic              sck_cur;
    logic              cs_cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_ch   <= '0;
            cs_ch    <= '1;
            si_ch    <= '0;
            sck_prev <= 1'b0;
            cs_prev  <= 1'b1;
        end else begin
            sck_ch   <= (sck_ch << 1) | STAGES'(sck_pin);
            cs_ch    <= (cs_ch << 1) | STAGES'(cs_n_pin);
            si_ch    <= (si_ch << 1) | STAGES'(si_pin);
            sck_prev <= sck_cur;
            cs_prev  <= cs_cur;
        end
    end

    assign sck_cur = sck_ch[STAGES-1];
    assign cs_cur  = cs_ch[STAGES-1];

    always_comb begin
        rx_ev.cs_act   = ~cs_cur;
        rx_ev.cs_stop  = cs_cur & ~cs_prev;
        rx_ev.sck_rise = ~cs_cur & sck_cur & ~sck_prev;
        rx_ev.si_bit   = si_ch[STAGES-1];
    end

    assign sck_fall = ~cs_cur & ~sck_cur & sck_prev;
endmodule

// File: rtl/spiflash_rx_framer.sv
module spiflash_rx_framer
    import spiflash_fe_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    localparam int ADDR_W = ADDR_BYTES * BYTE_W,
    localparam int IDX_W  = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  rx_events_t        rx_ev,
    output bitidx_t           bit_cnt,
    output logic              opc_valid,
    output byte_t             opc,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_valid,
    output byte_t             wr_byte,
    output logic              frame_end,
    output logic              frame_clean
);
    frame_phase_e      phase;
    byte_t             rx_sh;
    byte_t             rx_next;
    logic [IDX_W-1:0]  addr_idx;

    assign rx_next = push_msb_first(rx_sh, rx_ev.si_bit);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt     <= '0;
            rx_sh       <= '0;
            phase       <= PH_OPCODE;
            addr_idx    <= '0;
            opc_valid   <= 1'b0;
            opc         <= '0;
            addr_valid  <= 1'b0;
            addr        <= '0;
            wr_valid    <= 1'b0;
            wr_byte     <= '0;
            frame_end   <= 1'b0;
            frame_clean <= 1'b0;
        end else begin
            opc_valid  <= 1'b0;
            addr_valid <= 1'b0;
            wr_valid   <= 1'b0;
            frame_end  <= 1'b0;
            if (rx_ev.cs_stop) begin
                frame_end   <= 1'b1;
                frame_clean <= at_byte_edge(bit_cnt);
            end
            if (!rx_ev.cs_act) begin
                bit_cnt  <= '0;
                rx_sh    <= '0;
                phase    <= PH_OPCODE;
                addr_idx <= '0;
            end else if (rx_ev.sck_rise) begin
                bit_cnt <= bit_cnt + 1'b1;
                rx_sh   <= rx_next;
                if (last_bit(bit_cnt)) begin
                    unique case (phase)
                        PH_OPCODE: begin
                            opc       <= rx_next;
                            opc_valid <= 1'b1;
                            phase     <= PH_ADDRESS;
                        end
                        PH_ADDRESS: begin
                            addr     <= (addr << BYTE_W) | ADDR_W'(rx_next);
                            addr_idx <= addr_idx + 1'b1;
                            if (addr_idx == IDX_W'(ADDR_BYTES - 1)) begin
                                addr_valid <= 1'b1;
                                phase      <= PH_PAYLOAD;
                            end
                        end
                        default: begin
                            wr_byte  <= rx_next;
                            wr_valid <= 1'b1;
                        end
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/spiflash_tx_shifter.sv
module spiflash_tx_shifter
    import spiflash_fe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cs_act,
    input  logic  sck_fall,
    input  logic  byte_edge,
    input  logic  rd_en,
    input  byte_t rd_data,
    output logic  so_q,
    output logic  oe_q,
    output logic  rd_take
);
    byte_t tx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh   <= '0;
            so_q    <= 1'b0;
            oe_q    <= 1'b0;
            rd_take <= 1'b0;
        end else begin
            rd_take <= 1'b0;
            if (!cs_act) begin
                oe_q <= 1'b0;
            end else if (sck_fall) begin
                if (byte_edge) begin
                    if (rd_en) begin
                        // first bit straight from the core's byte
                        so_q    <= rd_data[BYTE_W-1];
                        tx_sh   <= {rd_data[BYTE_W-2:0], 1'b0};
                        oe_q    <= 1'b1;
                        rd_take <= 1'b1;
                    end else begin
                        oe_q <= 1'b0;
                    end
                end else begin
                    so_q  <= tx_sh[BYTE_W-1];
                    tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/spiflash_serial_frontend.sv
module spiflash_serial_frontend
    import spiflash_fe_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_BYTES  = 3,
    localparam int ADDR_W = ADDR_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_si,
    output logic              spi_so,
    output logic              spi_so_oe,
    output logic              cmd_valid,
    output logic [7:0]        cmd_opcode,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr_value,
    output logic              wdat_valid,
    output logic [7:0]        wdat_byte,
    input  logic              rdat_en,
    input  logic [7:0]        rdat_byte,
    output logic              rdat_take,
    output logic              frame_done,
    output logic              frame_whole
);
    rx_events_t rx_ev;
    logic       sck_fall;
    bitidx_t    bit_cnt;
    logic       so_q;
    logic       so_oe_q;

    spiflash_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .sck_pin  (spi_sck),
        .cs_n_pin (spi_cs_n),
        .si_pin   (spi_si),
        .rx_ev    (rx_ev),
        .sck_fall (sck_fall)
    );

    spiflash_rx_framer #(.ADDR_BYTES(ADDR_BYTES)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .rx_ev       (rx_ev),
        .bit_cnt     (bit_cnt),
        .opc_valid   (cmd_valid),
        .opc         (cmd_opcode),
        .addr_valid  (addr_valid),
        .addr        (addr_value),
        .wr_valid    (wdat_valid),
        .wr_byte     (wdat_byte),
        .frame_end   (frame_done),
        .frame_clean (frame_whole)
    );

    spiflash_tx_shifter u_tx (
        .clk       (clk),
        .rst       (rst),
        .cs_act    (rx_ev.cs_act),
        .sck_fall  (sck_fall),
        .byte_edge (at_byte_edge(bit_cnt)),
        .rd_en     (rdat_en),
        .rd_data   (rdat_byte),
        .so_q      (so_q),
        .oe_q      (so_oe_q),
        .rd_take   (rdat_take)
    );

    // pad release follows the raw pins without waiting for the synchronizer
    assign spi_so_oe = so_oe_q & ~spi_cs_n & ~rst;
    assign spi_so    = spi_so_oe & so_q;
endmodule

// File: rtl/spiflash_serial_frontend_chk.sv
module spiflash_serial_frontend_chk (
    input logic clk,
    input logic rst,
    input logic spi_cs_n,
    input logic spi_so_oe,
    input logic cmd_valid,
    input logic addr_valid,
    input logic wdat_valid,
    input logic rdat_take,
    input logic so_q,
    input logic sck_fall_evt
);
    // R7
    pad_released_chk: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_so_oe);

    // R10
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_valid, addr_valid, wdat_valid}));

    // R10
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R10
    addr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        addr_valid |=> !addr_valid);

    // R5
    so_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sck_fall_evt |=> $stable(so_q));

    // R5
    take_drives_chk: assert property (@(posedge clk) disable iff (rst)
        rdat_take |-> spi_so_oe);
endmodule

bind spiflash_serial_frontend spiflash_serial_frontend_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .spi_cs_n     (spi_cs_n),
    .spi_so_oe    (spi_so_oe),
    .cmd_valid    (cmd_valid),
    .addr_valid   (addr_valid),
    .wdat_valid   (wdat_valid),
    .rdat_take    (rdat_take),
    .so_q         (so_q),
    .sck_fall_evt (sck_fall)
);

// File: tb/spiflash_serial_frontend_test.sv
`timescale 1ns/1ps
module spiflash_serial_frontend_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        si = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_byte = 8'h00;
    logic        so, oe, cmd_valid, addr_valid, wdat_valid, rdat_take;
    logic        frame_done, frame_whole;
    logic [7:0]  cmd_opcode, wdat_byte;
    logic [23:0] addr_value;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    int opc_cnt = 0, addr_cnt = 0, wr_cnt = 0, fe_cnt = 0, strobe_seen = 0;
    logic [7:0]  last_opc = 8'h00;
    logic [23:0] last_addr = 24'h0;
    logic        last_whole = 1'b0;
    logic [7:0]  wr_log [0:31];
    logic [7:0]  miso_cap [0:1][0:2];
    logic [7:0]  wcap [0:1][0:1];

    always #2 clk = ~clk;

    spiflash_serial_frontend uut (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
        .spi_so(so), .spi_so_oe(oe),
        .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
        .addr_valid(addr_valid), .addr_value(addr_value),
        .wdat_valid(wdat_valid), .wdat_byte(wdat_byte),
        .rdat_en(rd_en), .rdat_byte(rd_byte), .rdat_take(rdat_take),
        .frame_done(frame_done), .frame_whole(frame_whole)
    );

    // core model and strobe log
    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                if (cmd_valid | addr_valid | wdat_valid | rdat_take | frame_done)
                    strobe_seen++;
            end else begin
                if (cmd_valid) begin opc_cnt++; last_opc = cmd_opcode; end
                if (addr_valid) begin
                    addr_cnt++; last_addr = addr_value;
                    if (cmd_opcode == 8'h03) begin rd_en = 1'b1; rd_byte = addr_value[7:0]; end
                end
                if (wdat_valid) begin wr_log[wr_cnt % 32] = wdat_byte; wr_cnt++; end
                if (rdat_take) rd_byte = rd_byte + 8'h11;
                if (frame_done) begin fe_cnt++; last_whole = frame_whole; rd_en = 1'b0; end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic frame_open(input bit m3);
        sck = m3;
        #37;
        cs_n = 1'b0;
        #40;
    endtask

    task automatic frame_close();
        #40;
        cs_n = 1'b1;
        #200;
    endtask

    task automatic xfer(input bit m3, input logic [7:0] tx, input int nbits,
                        output logic [7:0] rx, output bit drove);
        rx = 8'h00;
        drove = 0;
        for (int i = 7; i >= 8 - nbits; i--) begin
            if (m3) sck = 1'b0;
            si = tx[i];
            #38;
            if (oe) begin rx[i] = so; drove = 1; end
            sck = 1'b1;
            #40;
            if (!m3) sck = 1'b0;
        end
    endtask

    task automatic run_read(input bit m3);
        int o = opc_cnt, a = addr_cnt, f = fe_cnt;
        logic [7:0] r; bit d; bit hd = 0;
        frame_open(m3);
        xfer(m3, 8'h03, 8, r, d); hd |= d;
        xfer(m3, 8'h12, 8, r, d); hd |= d;
        xfer(m3, 8'h34, 8, r, d); hd |= d;
        xfer(m3, 8'h56, 8, r, d); hd |= d;
        for (int k = 0; k < 3; k++) begin
            xfer(m3, 8'h00, 8, r, d);
            miso_cap[m3][k] = r;
            check("R5", {24'h0, r}, {24'h0, 8'h56 + 8'(k) * 8'h11}, "read byte");
            check("R5", {31'h0, d}, 32'h1, "pad driven in read byte");
        end
        frame_close();
        check("R2", {24'h0, last_opc}, 32'h03, "command byte");
        check("R10", opc_cnt, o + 1, "command strobes per frame");
        check("R3", {8'h0, last_addr}, 32'h123456, "address");
        check("R10", addr_cnt, a + 1, "address strobes per frame");
        check("R11", {31'h0, hd}, 32'h0, "pad driven in header");
        check("R9", fe_cnt, f + 1, "frame end count");
        check("R9", {31'h0, last_whole}, 32'h1, "whole frame flag");
        check("R7", {31'h0, oe}, 32'h0, "pad after deselect");
    endtask

    task automatic run_write(input bit m3);
        int w = wr_cnt;
        logic [7:0] r; bit d; bit any = 0;
        frame_open(m3);
        xfer(m3, 8'h02, 8, r, d); any |= d;
        xfer(m3, 8'h00, 8, r, d); any |= d;
        xfer(m3, 8'hA5, 8, r, d); any |= d;
        xfer(m3, 8'hC3, 8, r, d); any |= d;
        xfer(m3, 8'h3C, 8, r, d); any |= d;
        xfer(m3, 8'hC3, 8, r, d); any |= d;
        frame_close();
        wcap[m3][0] = wr_log[w % 32];
        wcap[m3][1] = wr_log[(w + 1) % 32];
        check("R4", wr_cnt, w + 2, "payload strobes");
        check("R4", {24'h0, wcap[m3][0]}, 32'h3C, "payload byte 0");
        check("R4", {24'h0, wcap[m3][1]}, 32'hC3, "payload byte 1");
        check("R3", {8'h0, last_addr}, 32'h00A5C3, "write address");
        check("R11", {31'h0, any}, 32'h0, "pad driven without read enable");
    endtask

    task automatic run_abort();
        int o = opc_cnt, a = addr_cnt, f = fe_cnt;
        logic [7:0] r; bit d;
        frame_open(0);
        xfer(0, 8'hFF, 5, r, d);
        frame_close();
        check("R8", opc_cnt, o, "no command from partial byte");
        check("R8", {31'h0, last_whole}, 32'h0, "partial frame flag");
        check("R9", fe_cnt, f + 1, "frame end on abort");
        frame_open(1);
        xfer(1, 8'h05, 8, r, d);
        xfer(1, 8'hFF, 3, r, d);
        frame_close();
        check("R8", {24'h0, last_opc}, 32'h05, "fresh command after abort");
        check("R8", addr_cnt, a, "no address from partial byte");
        check("R8", {31'h0, last_whole}, 32'h0, "partial frame flag mode 3");
        frame_open(0);
        xfer(0, 8'hA7, 8, r, d);
        xfer(0, 8'h01, 8, r, d);
        xfer(0, 8'h02, 8, r, d);
        xfer(0, 8'h03, 8, r, d);
        frame_close();
        check("R8", {24'h0, last_opc}, 32'hA7, "alignment after abort");
        check("R8", {8'h0, last_addr}, 32'h010203, "address after abort");
    endtask

    task automatic run_reset_midread();
        logic [7:0] r; bit d;
        frame_open(0);
        xfer(0, 8'h03, 8, r, d);
        xfer(0, 8'h12, 8, r, d);
        xfer(0, 8'h34, 8, r, d);
        xfer(0, 8'h56, 8, r, d);
        xfer(0, 8'h00, 4, r, d);
        check("R7", {31'h0, oe}, 32'h1, "pad driven before reset");
        rst = 1'b1;
        #1;
        check("R7", {31'h0, oe}, 32'h0, "pad in reset");
        #40;
        check("R1", {31'h0, oe}, 32'h0, "pad held in reset");
        cs_n = 1'b1;
        rd_en = 1'b0;
        #40;
        rst = 1'b0;
        #100;
        check("R1", {31'h0, oe}, 32'h0, "pad after reset release");
    endtask

    initial begin
        cs_n = 1'b0;
        #60;
        check("R7", {31'h0, oe}, 32'h0, "pad in reset while selected");
        cs_n = 1'b1;
        #40;
        rst = 1'b0;
        #100;
        check("R1", strobe_seen, 0, "strobes during reset");
        check("R1", {31'h0, oe}, 32'h0, "pad after reset");
        check("R1", fe_cnt + opc_cnt, 0, "no events after reset");
        run_read(0);
        run_read(1);
        for (int k = 0; k < 3; k++)
            check("R6", {24'h0, miso_cap[1][k]}, {24'h0, miso_cap[0][k]}, "mode 3 vs mode 0 read byte");
        run_write(0);
        run_write(1);
        check("R6", {16'h0, wcap[1][0], wcap[1][1]}, {16'h0, wcap[0][0], wcap[0][1]}, "mode 3 vs mode 0 payload");
        run_abort();
        run_reset_midread();
        run_read(1);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #600000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule